// File: doc/BRIEF.md
# ADC Regular-Group Conversion Sequencer

This block decides which analog channel a successive-approximation converter samples next, for how long, and what happens to the result. Software fills a rank table of up to sixteen channel numbers and a per-channel table of 3-bit sampling codes. A conversion run starts on a software start pulse or on a chosen edge of an external trigger line. The block then walks the ranks upward from rank 1. For each rank it presents the channel and drives a sample phase and then a convert phase to a converter stub. At the end of the convert phase it captures the stub's 12-bit code.

The captured code is reduced to the selected resolution and placed in a 16-bit data word, either right- or left-justified. A sticky end-of-conversion flag is raised after every rank or only at the end of the sequence. In per-rank mode, a result that completes while that flag is still set raises a sticky overrun flag. Single, scan, continuous and discontinuous (chunked) operation are supported. A stop request ends a run cleanly at the next conversion boundary.

Top module: `adc_rank_sequencer`

## Requirements
- R1: With scan enabled, a run converts ranks 1 to n in ascending order, where n = cfg_seq_len + 1 (1 to 16), and each result belongs to the channel held in that rank.
- R2: With scan disabled, a run converts only the channel in rank 1, exactly once, whatever cfg_seq_len holds.
- R3: With cfg_disc set, scan enabled and continuous disabled, each trigger converts the next chunk of cfg_disc_len + 1 ranks (1 to 8). The rank position is held between triggers. After a chunk that reaches rank n, even a short one, the next trigger starts again at rank 1.
- R4: cfg_disc has no effect when scan is disabled or continuous mode is enabled.
- R5: In continuous mode the sequence restarts at rank 1 directly after rank n, with no new trigger, until stopped.
- R6: cfg_edge selects the start source: 0 = sw_start pulse, 1 = rising ext_trig edge, 2 = falling edge, 3 = both edges. Any source not selected starts nothing.
- R7: Each conversion holds conv_sample for S clocks and then conv_convert for P clocks. S is set by the channel's sampling code: codes 0 to 7 give 3, 15, 28, 56, 84, 112, 144 and 480 clocks. P is 12, 11, 9 or 7 for cfg_res = 0, 1, 2, 3.
- R8: cfg_res = 0, 1, 2, 3 selects 12, 10, 8 or 6 bits, taken from the top of conv_raw. With cfg_left = 0 the result LSB sits at data_out bit 0. With cfg_left = 1 the result MSB sits at bit 15. Unused bits are zero.
- R9: With cfg_eoc_each = 1, eoc is set after every conversion. With cfg_eoc_each = 0, eoc is set only after the conversion of rank n. eoc stays set until eoc_clr.
- R10: ovr is set when a conversion completes with cfg_eoc_each = 1 while eoc is still set and not being cleared in that cycle. It is never set with cfg_eoc_each = 0, and it stays set until ovr_clr.
- R11: stop_req during a run lets the current conversion finish and deliver its result, then the block goes idle. stop_req while idle returns the rank position to rank 1.
- R12: busy is high exactly while a sample or convert phase is in progress, and it is low after reset and between discontinuous chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_scan | input | 1 | Scan through ranks 1..n |
| cfg_cont | input | 1 | Restart the sequence automatically |
| cfg_disc | input | 1 | Chunked (discontinuous) operation |
| cfg_disc_len | input | 3 | Chunk size minus one |
| cfg_seq_len | input | 4 | Sequence length minus one |
| cfg_res | input | 2 | Resolution select (12/10/8/6 bits) |
| cfg_left | input | 1 | Left-justify the result |
| cfg_eoc_each | input | 1 | End-of-conversion flag per rank (1) or per sequence (0) |
| cfg_edge | input | 2 | Start source: software, rising, falling, both |
| rank_wr | input | 1 | Write strobe for the rank table |
| rank_idx | input | 4 | Rank table index (0 = rank 1) |
| rank_ch | input | 5 | Channel number to store |
| smp_wr | input | 1 | Write strobe for the sampling-code table |
| smp_ch | input | 5 | Channel whose code is written |
| smp_code | input | 3 | Sampling code |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | External trigger level |
| stop_req | input | 1 | Stop request |
| eoc_clr | input | 1 | Clear the end-of-conversion flag |
| ovr_clr | input | 1 | Clear the overrun flag |
| conv_raw | input | 12 | Converter result code |
| conv_chan | output | 5 | Channel being converted |
| conv_sample | output | 1 | Sample phase active |
| conv_convert | output | 1 | Convert phase active |
| data_out | output | 16 | Formatted result of the latest conversion |
| eoc | output | 1 | End-of-conversion flag |
| ovr | output | 1 | Overrun flag |
| busy | output | 1 | A conversion is in progress |

## Verification
On every cycle the assertions check the following:
- a sample phase always hands over to a convert phase;
- the channel stays fixed for the whole of a conversion;
- the data word changes only at the end of a convert phase;
- overrun appears only on top of a pending per-rank flag;
- a sequence-end flag rises only on rank n;
- a stop while idle rewinds the rank position.

Only the bench scenarios can show the rest: the rank order across all sequence lengths, the chunk boundaries and wrap for every length and chunk size, the exact phase lengths for each code and resolution, the formatted values, and which trigger edges start a run.

// File: rtl/adc_rank_sequencer.sv
module adc_rank_sequencer #(
  parameter int NUM_CH   = 19,
  parameter int CH_W     = 5,
  parameter int NUM_RANK = 16,
  parameter int ADC_W    = 12,
  parameter int DATA_W   = 16,
  parameter int SMP_W    = 3,
  parameter int DISC_W   = 3,
  parameter int CNT_W    = 9,
  localparam int RANK_W  = $clog2(NUM_RANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_scan,
  input  logic              cfg_cont,
  input  logic              cfg_disc,
  input  logic [DISC_W-1:0] cfg_disc_len,
  input  logic [RANK_W-1:0] cfg_seq_len,
  input  logic [1:0]        cfg_res,
  input  logic              cfg_left,
  input  logic              cfg_eoc_each,
  input  logic [1:0]        cfg_edge,
  input  logic              rank_wr,
  input  logic [RANK_W-1:0] rank_idx,
  input  logic [CH_W-1:0]   rank_ch,
  input  logic              smp_wr,
  input  logic [CH_W-1:0]   smp_ch,
  input  logic [SMP_W-1:0]  smp_code,
  input  logic              sw_start,
  input  logic              ext_trig,
  input  logic              stop_req,
  input  logic              eoc_clr,
  input  logic              ovr_clr,
  input  logic [ADC_W-1:0]  conv_raw,
  output logic [CH_W-1:0]   conv_chan,
  output logic              conv_sample,
  output logic              conv_convert,
  output logic [DATA_W-1:0] data_out,
  output logic              eoc,
  output logic              ovr,
  output logic              busy
);
  localparam int PAD = DATA_W - ADC_W;

  typedef enum logic [1:0] {ST_IDLE, ST_SMP, ST_CNV} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [RANK_W-1:0] rank_ptr;
  logic [DISC_W-1:0] chunk;
  logic              stop_pend;
  logic              ext_q;
  logic [CH_W-1:0]   rank_tbl [NUM_RANK];
  logic [SMP_W-1:0]  smp_tbl  [NUM_CH];

  function automatic logic [CNT_W-1:0] smp_clocks(input logic [SMP_W-1:0] code);
    case (code)
      3'd0:    smp_clocks = CNT_W'(3);
      3'd1:    smp_clocks = CNT_W'(15);
      3'd2:    smp_clocks = CNT_W'(28);
      3'd3:    smp_clocks = CNT_W'(56);
      3'd4:    smp_clocks = CNT_W'(84);
      3'd5:    smp_clocks = CNT_W'(112);
      3'd6:    smp_clocks = CNT_W'(144);
      default: smp_clocks = CNT_W'(480);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] proc_clocks(input logic [1:0] res);
    case (res)
      2'd0:    proc_clocks = CNT_W'(12);
      2'd1:    proc_clocks = CNT_W'(11);
      2'd2:    proc_clocks = CNT_W'(9);
      default: proc_clocks = CNT_W'(7);
    endcase
  endfunction

  logic              disc_on, last, chunk_end, done_ev, trig, abort;
  logic [RANK_W-1:0] eff_last, ptr_inc, sel_ptr;
  logic [CH_W-1:0]   sel_ch;
  logic [SMP_W-1:0]  sel_code;
  logic [DATA_W-1:0] ext_raw, fmt_word;

  assign disc_on   = cfg_disc & cfg_scan & ~cfg_cont;
  assign eff_last  = cfg_scan ? cfg_seq_len : '0;
  assign last      = (rank_ptr == eff_last);
  assign chunk_end = disc_on & (chunk == cfg_disc_len);
  assign ptr_inc   = last ? '0 : rank_ptr + 1'b1;
  assign sel_ptr   = (st == ST_IDLE) ? rank_ptr : ptr_inc;
  assign sel_ch    = rank_tbl[sel_ptr];
  assign sel_code  = (sel_ch < CH_W'(NUM_CH)) ? smp_tbl[sel_ch] : '0;
  assign done_ev   = (st == ST_CNV) && (cnt == '0);
  assign abort     = stop_pend | stop_req;
  assign trig      = (cfg_edge == 2'd0) ? sw_start
                   : ((cfg_edge[0] & ext_trig & ~ext_q) | (cfg_edge[1] & ~ext_trig & ext_q));

  assign ext_raw  = {{PAD{1'b0}}, conv_raw} >> (2 * int'(cfg_res));
  assign fmt_word = cfg_left ? (ext_raw << (PAD + 2 * int'(cfg_res))) : ext_raw;

  assign conv_sample  = (st == ST_SMP);
  assign conv_convert = (st == ST_CNV);
  assign busy         = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RANK; i++) rank_tbl[i] <= '0;
      for (int i = 0; i < NUM_CH; i++) smp_tbl[i] <= '0;
    end else begin
      if (rank_wr) rank_tbl[rank_idx] <= rank_ch;
      if (smp_wr && smp_ch < CH_W'(NUM_CH)) smp_tbl[smp_ch] <= smp_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rank_ptr  <= '0;
      chunk     <= '0;
      stop_pend <= 1'b0;
      ext_q     <= 1'b0;
      conv_chan <= '0;
      data_out  <= '0;
    end else begin
      ext_q <= ext_trig;
      case (st)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          if (stop_req) begin
            rank_ptr <= '0;
            chunk    <= '0;
          end else if (trig) begin
            chunk     <= '0;
            conv_chan <= sel_ch;
            cnt       <= smp_clocks(sel_code) - 1'b1;
            st        <= ST_SMP;
          end
        end
        ST_SMP: begin
          if (stop_req) stop_pend <= 1'b1;
          if (cnt == '0) begin
            cnt <= proc_clocks(cfg_res) - 1'b1;
            st  <= ST_CNV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (stop_req) stop_pend <= 1'b1;
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            data_out <= fmt_word;
            if (abort) begin
              st        <= ST_IDLE;
              rank_ptr  <= '0;
              chunk     <= '0;
              stop_pend <= 1'b0;
            end else if (last && !cfg_cont) begin
              st       <= ST_IDLE;
              rank_ptr <= '0;
              chunk    <= '0;
            end else if (!last && chunk_end) begin
              st       <= ST_IDLE;
              rank_ptr <= ptr_inc;
              chunk    <= '0;
            end else begin
              rank_ptr  <= ptr_inc;
              chunk     <= last ? '0 : chunk + 1'b1;
              conv_chan <= sel_ch;
              cnt       <= smp_clocks(sel_code) - 1'b1;
              st        <= ST_SMP;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoc <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (done_ev && (cfg_eoc_each || last)) eoc <= 1'b1;
      else if (eoc_clr)                      eoc <= 1'b0;
      if (done_ev && cfg_eoc_each && eoc && !eoc_clr) ovr <= 1'b1;
      else if (ovr_clr)                               ovr <= 1'b0;
    end
  end

  a_r7_sample_then_convert: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_sample) |-> conv_convert);

  a_r1_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_convert || (conv_sample && $past(conv_sample))) |-> $stable(conv_chan));

  a_r8_data_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_convert) |-> $stable(data_out));

  a_r10_ovr_on_pending_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($past(eoc) && $past(cfg_eoc_each)));

  a_r9_seq_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eoc) && !$past(cfg_eoc_each)) |-> $past(rank_ptr == eff_last));

  a_r11_idle_stop_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_req && !busy) |-> (rank_ptr == '0));
endmodule

// File: tb/adc_rank_sequencer_test.sv
`timescale 1ns/1ps
module adc_rank_sequencer_test;
  logic clk = 0, rst_n = 0;
  logic cfg_scan = 0, cfg_cont = 0, cfg_disc = 0, cfg_left = 0, cfg_eoc_each = 1;
  logic [2:0] cfg_disc_len = 0;
  logic [3:0] cfg_seq_len = 0;
  logic [1:0] cfg_res = 0, cfg_edge = 0;
  logic rank_wr = 0, smp_wr = 0, sw_start = 0, ext_trig = 0, stop_req = 0, eoc_clr = 0, ovr_clr = 0;
  logic [3:0] rank_idx = 0;
  logic [4:0] rank_ch = 0, smp_ch = 0;
  logic [2:0] smp_code = 0;
  logic [11:0] conv_raw;
  logic [4:0] conv_chan;
  logic conv_sample, conv_convert, eoc, ovr, busy;
  logic [15:0] data_out;

  always #2.5 clk = ~clk;

  assign conv_raw = 12'((int'(conv_chan) * 397 + 291) % 4096);

  adc_rank_sequencer uut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int lg_ch [64];
  int lg_d  [64];
  int logn, smp_cnt, cnv_cnt, busy_cnt;
  int rk [16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fmt(input int ch, input int r, input bit l);
    int v;
    v = ((ch * 397 + 291) % 4096) >> (2 * r);
    if (l) v = (v << (4 + 2 * r)) & 16'hFFFF;
    return v;
  endfunction

  function automatic int smp_len(input int code);
    case (code)
      0: return 3;   1: return 15;  2: return 28;  3: return 56;
      4: return 84;  5: return 112; 6: return 144; default: return 480;
    endcase
  endfunction

  function automatic int proc_len(input int r);
    case (r) 0: return 12; 1: return 11; 2: return 9; default: return 7; endcase
  endfunction

  task automatic collect(input int stop_after, input int maxcyc);
    bit pcv, seen;
    int pch;
    pcv = 0; seen = 0; pch = 0;
    logn = 0; smp_cnt = 0; cnv_cnt = 0; busy_cnt = 0;
    for (int c = 0; c < maxcyc; c++) begin
      @(negedge clk);
      sw_start = 0;
      stop_req = 0;
      if (pcv && !conv_convert && logn < 64) begin
        lg_ch[logn] = pch;
        lg_d[logn]  = data_out;
        logn++;
        if (logn == stop_after) stop_req = 1;
      end
      if (conv_sample) smp_cnt++;
      if (conv_convert) cnv_cnt++;
      if (busy) begin busy_cnt++; seen = 1; end
      pcv = conv_convert;
      pch = conv_chan;
      if (seen && !busy) break;
    end
  endtask

  task automatic sw_run(input int stop_after, input int maxcyc);
    @(negedge clk) sw_start = 1;
    collect(stop_after, maxcyc);
  endtask

  task automatic rewind();
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
  endtask

  task automatic clr_flags();
    @(negedge clk) begin eoc_clr = 1; ovr_clr = 1; end
    @(negedge clk) begin eoc_clr = 0; ovr_clr = 0; end
  endtask

  task automatic put_rank(input int i, input int ch);
    @(negedge clk) begin rank_wr = 1; rank_idx = 4'(i); rank_ch = 5'(ch); end
    @(negedge clk) rank_wr = 0;
  endtask

  task automatic put_smp(input int ch, input int code);
    @(negedge clk) begin smp_wr = 1; smp_ch = 5'(ch); smp_code = 3'(code); end
    @(negedge clk) smp_wr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R12 reset busy", busy, 0);
    chk(eoc == 0 && ovr == 0, "R9 reset flags", {eoc, ovr}, 0);
    chk(data_out == 0, "R8 reset data", data_out, 0);
    chk(conv_sample == 0 && conv_convert == 0, "R12 reset phases", {conv_sample, conv_convert}, 0);

    for (int i = 0; i < 16; i++) begin
      rk[i] = (i * 7 + 3) % 19;
      put_rank(i, rk[i]);
    end

    // R1: every sequence length, ascending ranks
    cfg_scan = 1;
    for (int n = 1; n <= 16; n++) begin
      cfg_seq_len = 4'(n - 1);
      sw_run(-1, 2000);
      chk(logn == n, "R1 rank count", logn, n);
      for (int j = 0; j < n && j < logn; j++) begin
        chk(lg_ch[j] == rk[j], "R1 rank order", lg_ch[j], rk[j]);
        chk(lg_d[j] == fmt(rk[j], 0, 0), "R1 result", lg_d[j], fmt(rk[j], 0, 0));
      end
      chk(busy == 0, "R12 idle after run", busy, 0);
    end

    // R2 and R4: scan off converts rank 1 once, chunking ignored
    cfg_scan = 0; cfg_seq_len = 15; cfg_disc = 1; cfg_disc_len = 0;
    sw_run(-1, 2000);
    chk(logn == 1, "R2 single count", logn, 1);
    chk(lg_ch[0] == rk[0], "R2 rank 1 channel", lg_ch[0], rk[0]);
    cfg_disc = 0;

    // R8: resolution and alignment sweep
    for (int r = 0; r < 4; r++)
      for (int l = 0; l < 2; l++)
        for (int c = 0; c < 19; c += 6) begin
          cfg_res = 2'(r); cfg_left = l[0];
          put_rank(0, c);
          sw_run(-1, 2000);
          chk(logn == 1 && lg_d[0] == fmt(c, r, l[0]), "R8 format", lg_d[0], fmt(c, r, l[0]));
        end
    cfg_left = 0;

    // R7 and R12: phase lengths per code and resolution
    put_rank(0, 5);
    for (int code = 0; code < 8; code++) begin
      put_smp(5, code);
      for (int r = 0; r < 4; r++) begin
        cfg_res = 2'(r);
        sw_run(-1, 2000);
        chk(smp_cnt == smp_len(code), "R7 sample clocks", smp_cnt, smp_len(code));
        chk(cnv_cnt == proc_len(r), "R7 convert clocks", cnv_cnt, proc_len(r));
        chk(busy_cnt == smp_len(code) + proc_len(r), "R12 busy span", busy_cnt, smp_len(code) + proc_len(r));
      end
    end
    put_smp(5, 0);
    put_rank(0, rk[0]);
    cfg_res = 0;

    // R3: chunked runs for every length and chunk size
    cfg_scan = 1; cfg_disc = 1;
    for (int n = 1; n <= 16; n += 3)
      for (int k = 1; k <= 8; k++) begin
        int p, m, trigs;
        cfg_seq_len = 4'(n - 1); cfg_disc_len = 3'(k - 1);
        rewind();
        p = 0;
        trigs = (n + k - 1) / k + 1;
        for (int t = 0; t < trigs; t++) begin
          m = (k < n - p) ? k : n - p;
          sw_run(-1, 2000);
          chk(logn == m, "R3 chunk size", logn, m);
          chk(logn > 0 && lg_ch[0] == rk[p], "R3 chunk start", lg_ch[0], rk[p]);
          chk(busy == 0, "R12 idle between chunks", busy, 0);
          p = (p + m) % n;
        end
      end

    // R11: stop while idle rewinds a held chunk position
    cfg_seq_len = 5; cfg_disc_len = 1;
    rewind();
    sw_run(-1, 2000);
    rewind();
    sw_run(-1, 2000);
    chk(lg_ch[0] == rk[0], "R11 idle stop rewinds", lg_ch[0], rk[0]);

    // R4 and R5: continuous overrides chunking, wraps without trigger
    rewind();
    cfg_cont = 1; cfg_seq_len = 2; cfg_disc_len = 0;
    sw_run(6, 3000);
    chk(logn == 7, "R4 R5 continuous count", logn, 7);
    for (int j = 0; j < 7 && j < logn; j++)
      chk(lg_ch[j] == rk[j % 3], "R5 wrap order", lg_ch[j], rk[j % 3]);
    cfg_disc = 0;

    // R11: stop mid-run, current conversion completes, restart at rank 1
    cfg_seq_len = 3;
    sw_run(1, 3000);
    chk(logn == 2, "R11 stop at boundary", logn, 2);
    chk(busy == 0, "R11 idle after stop", busy, 0);
    chk(lg_ch[1] == rk[1], "R11 last delivered rank", lg_ch[1], rk[1]);
    cfg_cont = 0;
    sw_run(-1, 3000);
    chk(logn == 4 && lg_ch[0] == rk[0], "R11 restart at rank 1", lg_ch[0], rk[0]);

    // R6: start source selection
    cfg_scan = 0;
    cfg_edge = 1;
    sw_run(-1, 40);
    chk(logn == 0 && busy_cnt == 0, "R6 sw ignored on edge mode", busy_cnt, 0);
    @(negedge clk) ext_trig = 1;
    collect(-1, 200);
    chk(logn == 1, "R6 rising starts", logn, 1);
    @(negedge clk) ext_trig = 0;
    collect(-1, 40);
    chk(logn == 0, "R6 falling ignored in rising mode", logn, 0);
    cfg_edge = 2;
    @(negedge clk) ext_trig = 1;
    collect(-1, 40);
    chk(logn == 0, "R6 rising ignored in falling mode", logn, 0);
    @(negedge clk) ext_trig = 0;
    collect(-1, 200);
    chk(logn == 1, "R6 falling starts", logn, 1);
    cfg_edge = 3;
    @(negedge clk) ext_trig = 1;
    collect(-1, 200);
    chk(logn == 1, "R6 both rising", logn, 1);
    @(negedge clk) ext_trig = 0;
    collect(-1, 200);
    chk(logn == 1, "R6 both falling", logn, 1);
    cfg_edge = 0;

    // R9 and R10: flag behaviour
    cfg_eoc_each = 1;
    clr_flags();
    chk(eoc == 0 && ovr == 0, "R9 cleared", {eoc, ovr}, 0);
    sw_run(-1, 200);
    chk(eoc == 1, "R9 per-rank flag", eoc, 1);
    chk(ovr == 0, "R10 no overrun first", ovr, 0);
    sw_run(-1, 200);
    chk(ovr == 1, "R10 overrun on pending flag", ovr, 1);
    clr_flags();
    chk(eoc == 0 && ovr == 0, "R10 flags cleared", {eoc, ovr}, 0);
    cfg_eoc_each = 0; cfg_scan = 1; cfg_disc = 1; cfg_seq_len = 2; cfg_disc_len = 0;
    rewind();
    sw_run(-1, 200);
    chk(eoc == 0, "R9 no flag mid sequence", eoc, 0);
    sw_run(-1, 200);
    chk(eoc == 0, "R9 no flag rank 2", eoc, 0);
    sw_run(-1, 200);
    chk(eoc == 1, "R9 flag at sequence end", eoc, 1);
    cfg_disc = 0;
    sw_run(-1, 400);
    chk(ovr == 0, "R10 no overrun per sequence", ovr, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule